// File: doc/BRIEF.md
# Serial Flash Power-Mode Controller

This block is the slave-side power-state keeper of a serial NOR flash. It watches chip select, the serial clock and four data lines, and captures the first byte of each frame as an opcode. The byte arrives either on one line over eight clocks or on four lines over two clocks. From the power-related opcodes it tracks three power modes: active, standby and deep power-down. It raises a flag that tells the command decoder to drop work, and it pulses a start signal to the shift-out logic when the device ID must be sent.

Sleep is entered only when a sleep opcode frame ends exactly on the eighth bit and no internal program, erase or write cycle is busy. The mode then changes after a fixed delay in system clocks. While asleep, or while that delay runs, the only opcodes honoured are wake-with-ID and a two-frame reset. All inputs are sampled synchronously in the system clock domain.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: After reset `pwr_mode` is 1 (standby), `cmd_block` is 0 and `id_start` is 0. The mode codes are 0 = active, 1 = standby, 2 = deep power-down.
- R2: In single-line mode (`quad_mode`=0) one bit is taken from `io_in[0]` on each rising edge of `sclk` while `cs_n` is low, most significant bit first. A frame of exactly 8 bits carrying 0xB9 raises `cmd_block` once `cs_n` rises.
- R3: In quad mode (`quad_mode`=1) each rising edge of `sclk` takes a nibble from `io_in[3:0]`, with `io_in[3]` as the most significant bit and the high nibble first. Two clocks carrying 0xB9 act the same as in R2.
- R4: A 0xB9 frame whose bit count at the rise of `cs_n` differs from 8 (for example 7, 9 or 16 bits, or 1 or 3 nibbles) has no effect: `cmd_block` stays 0 and the mode never becomes 2.
- R5: After a valid 0xB9 frame, `pwr_mode` reads 1 with `cmd_block` at 1 until the delay `TDP_CYC` has elapsed. After that `pwr_mode` reads 2.
- R6: During the delay and in deep power-down, all opcodes except 0xAB and the 0x66/0x99 pair are ignored. This includes write, program, erase and a repeated 0xB9. The mode and `cmd_block` are unchanged.
- R7: Once the eighth bit of 0xAB is taken, the block leaves the delay or deep power-down. `cmd_block` falls, `pwr_mode` reads 0 while `cs_n` is still low, and it reads 1 after `cs_n` rises.
- R8: Each completed 0xAB byte produces a single one-cycle `id_start` pulse in every mode.
- R9: A valid 0x66 frame followed directly by a valid 0x99 frame leaves the delay or deep power-down. Any other frame between the two disarms the pair.
- R10: While `busy` is 1, `pwr_mode` reads 0 even with `cs_n` high, and a 0xB9 frame is rejected with no later effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, data taken on its rising edge |
| io_in | input | 4 | Serial data lines; bit 0 only in single-line mode |
| quad_mode | input | 1 | 1 selects four-line opcode capture |
| busy | input | 1 | An internal program, erase or write cycle is running |
| pwr_mode | output | 2 | 0 active, 1 standby, 2 deep power-down |
| cmd_block | output | 1 | Command decoder must drop the current command |
| id_start | output | 1 | One-cycle pulse that starts device ID shift-out |

## Verification
Two events can coincide in one cycle. The first is the expiry of the sleep delay and the completion of a wake byte. The bench sends a quad sleep frame and follows it with a quad 0xAB after a gap that it sweeps across the whole delay window, so one of the sweeps lands on the expiry cycle. Each pass is judged by waiting past the delay and requiring `cmd_block` at 0 and the mode at standby, with one ID pulse per wake. The second case raises `busy` on the same clock edge as the rising `cs_n` that ends a valid sleep frame. That sleep must never take effect.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int OPC_W = 8;
  localparam int CNT_W = $clog2(2*OPC_W + 1);

  localparam logic [OPC_W-1:0] OPC_SLEEP  = 8'hB9;
  localparam logic [OPC_W-1:0] OPC_WAKE   = 8'hAB;
  localparam logic [OPC_W-1:0] OPC_RST_EN = 8'h66;
  localparam logic [OPC_W-1:0] OPC_RST_GO = 8'h99;

  typedef enum logic [1:0] {PM_ACTIVE = 2'd0, PM_STANDBY = 2'd1, PM_DEEP = 2'd2} pmode_t;
  typedef enum logic [1:0] {PS_RUN = 2'd0, PS_PEND = 2'd1, PS_DEEP = 2'd2} pstate_t;

  // bit count after one serial clock, saturating at two opcodes' worth
  function automatic logic [CNT_W-1:0] bits_after(input logic [CNT_W-1:0] cnt, input logic quad);
    logic [CNT_W:0] s;
    s = {1'b0, cnt} + (quad ? (CNT_W+1)'(4) : (CNT_W+1)'(1));
    if (s > (CNT_W+1)'(2*OPC_W)) s = (CNT_W+1)'(2*OPC_W);
    return s[CNT_W-1:0];
  endfunction

  // shift one bit or one nibble in, most significant first
  function automatic logic [OPC_W-1:0] shift_in(input logic [OPC_W-1:0] sr, input logic [3:0] io,
                                                input logic quad);
    return quad ? {sr[OPC_W-5:0], io} : {sr[OPC_W-2:0], io[0]};
  endfunction

  function automatic pmode_t mode_of(input pstate_t st, input logic cs_n, input logic busy);
    if (st == PS_DEEP) return PM_DEEP;
    if (st == PS_PEND) return PM_STANDBY;
    return (!cs_n || busy) ? PM_ACTIVE : PM_STANDBY;
  endfunction
endpackage

// File: rtl/flash_op_shift.sv
module flash_op_shift
  import fpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [3:0]       io_in,
  input  logic             quad,
  output logic             byte_stb,
  output logic [OPC_W-1:0] byte_val,
  output logic             cmd_stb,
  output logic             cmd_ok,
  output logic [OPC_W-1:0] cmd_op
);
  logic             sclk_q, cs_q;
  logic [CNT_W-1:0] cnt;
  logic [OPC_W-1:0] sr;
  logic             sclk_rise, cs_rise, in_byte;
  logic [CNT_W-1:0] cnt_nx;
  logic [OPC_W-1:0] sr_nx;

  assign sclk_rise = sclk && !sclk_q && !cs_n;
  assign cs_rise   = cs_n && !cs_q;
  assign in_byte   = cnt < CNT_W'(OPC_W);
  assign cnt_nx    = bits_after(cnt, quad);
  assign sr_nx     = shift_in(sr, io_in, quad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
      cnt      <= '0;
      sr       <= '0;
      byte_stb <= 1'b0;
      byte_val <= '0;
      cmd_stb  <= 1'b0;
      cmd_ok   <= 1'b0;
      cmd_op   <= '0;
    end else begin
      sclk_q   <= sclk;
      cs_q     <= cs_n;
      byte_stb <= 1'b0;
      cmd_stb  <= cs_rise;
      if (cs_rise) begin
        cmd_ok <= (cnt == CNT_W'(OPC_W));
        cmd_op <= sr;
      end
      if (cs_n) begin
        cnt <= '0;
      end else if (sclk_rise) begin
        cnt <= cnt_nx;
        if (in_byte) begin
          sr <= sr_nx;
          if (cnt_nx == CNT_W'(OPC_W)) begin
            byte_stb <= 1'b1;
            byte_val <= sr_nx;
          end
        end
      end
    end
  end

  assert_byte_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !byte_stb);
  assert_frame_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> (cnt == '0));
endmodule

// File: rtl/flash_dp_timer.sv
module flash_dp_timer #(
  parameter int TDP_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire
);
  localparam int TW = $clog2(TDP_CYC + 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= TW'(TDP_CYC);
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == TW'(1));

  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/flash_pwr_fsm.sv
module flash_pwr_fsm
  import fpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             busy,
  input  logic             byte_stb,
  input  logic [OPC_W-1:0] byte_val,
  input  logic             cmd_stb,
  input  logic             cmd_ok,
  input  logic [OPC_W-1:0] cmd_op,
  input  logic             tmr_expire,
  output logic             tmr_load,
  output logic [1:0]       pwr_mode,
  output logic             cmd_block,
  output logic             id_start
);
  pstate_t state, state_nx;
  logic    armed;
  logic    wake_evt, sleep_req, rst_go, asleep;
  pmode_t  mode_now;

  assign wake_evt  = byte_stb && (byte_val == OPC_WAKE);
  assign sleep_req = cmd_stb && cmd_ok && (cmd_op == OPC_SLEEP) && !busy;
  assign rst_go    = cmd_stb && cmd_ok && (cmd_op == OPC_RST_GO) && armed;
  assign asleep    = (state != PS_RUN);
  assign tmr_load  = (state == PS_RUN) && sleep_req;

  always_comb begin
    state_nx = state;
    case (state)
      PS_RUN:  if (sleep_req) state_nx = PS_PEND;
      PS_PEND: if (wake_evt || rst_go) state_nx = PS_RUN;
               else if (tmr_expire) state_nx = PS_DEEP;
      PS_DEEP: if (wake_evt || rst_go) state_nx = PS_RUN;
      default: state_nx = PS_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= PS_RUN;
      armed    <= 1'b0;
      id_start <= 1'b0;
    end else begin
      state    <= state_nx;
      id_start <= wake_evt;
      if (cmd_stb) armed <= cmd_ok && (cmd_op == OPC_RST_EN);
    end
  end

  assign mode_now  = mode_of(state, cs_n, busy);
  assign pwr_mode  = mode_now;
  assign cmd_block = asleep;

  assert_busy_reject_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_RUN && cmd_stb && cmd_ok && cmd_op == OPC_SLEEP && busy) |=> (state == PS_RUN));
  assert_bad_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_RUN && cmd_stb && !cmd_ok) |=> (state == PS_RUN));
  assert_deep_after_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_DEEP && $past(state) != PS_DEEP) |-> ($past(state) == PS_PEND));
  assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && asleep) |=> (state == PS_RUN));
  assert_id_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    id_start |=> !id_start);
endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl
  import fpc_pkg::*;
#(
  parameter int TDP_CYC = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sclk,
  input  logic [3:0] io_in,
  input  logic       quad_mode,
  input  logic       busy,
  output logic [1:0] pwr_mode,
  output logic       cmd_block,
  output logic       id_start
);
  logic             byte_stb, cmd_stb, cmd_ok, tmr_load, tmr_expire;
  logic [OPC_W-1:0] byte_val, cmd_op;

  flash_op_shift u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .io_in(io_in), .quad(quad_mode),
    .byte_stb(byte_stb), .byte_val(byte_val), .cmd_stb(cmd_stb), .cmd_ok(cmd_ok), .cmd_op(cmd_op)
  );

  flash_dp_timer #(.TDP_CYC(TDP_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .expire(tmr_expire)
  );

  flash_pwr_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(busy),
    .byte_stb(byte_stb), .byte_val(byte_val), .cmd_stb(cmd_stb), .cmd_ok(cmd_ok),
    .cmd_op(cmd_op), .tmr_expire(tmr_expire), .tmr_load(tmr_load),
    .pwr_mode(pwr_mode), .cmd_block(cmd_block), .id_start(id_start)
  );

  assert_reset_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pwr_mode != 2'd2 && !cmd_block));
endmodule

// File: tb/flash_pwr_ctrl_tb_top.sv
module flash_pwr_ctrl_tb_top;
  localparam int TDP = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic [3:0] io_in = 4'h0;
  logic       quad_mode = 1'b0;
  logic       busy = 1'b0;
  logic [1:0] pwr_mode;
  logic       cmd_block;
  logic       id_start;

  int errors = 0;
  int checks = 0;
  int id_cnt = 0;
  logic id_prev = 1'b0;
  logic id_wide = 1'b0;
  logic done = 1'b0;

  flash_pwr_ctrl #(.TDP_CYC(TDP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .io_in(io_in),
    .quad_mode(quad_mode), .busy(busy), .pwr_mode(pwr_mode),
    .cmd_block(cmd_block), .id_start(id_start)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) begin
      if (id_start) id_cnt = id_cnt + 1;
      if (id_start && id_prev) id_wide = 1'b1;
      id_prev = id_start;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    tick(2);
  endtask

  task automatic desel();
    sclk = 1'b0;
    cs_n = 1'b1;
    tick(3);
  endtask

  // clocks out n bits (single) or n nibbles (quad) from the top of pat
  task automatic shift(input logic [15:0] pat, input int n, input logic quad);
    quad_mode = quad;
    for (int i = 0; i < n; i++) begin
      if (quad) io_in = pat[15-4*i -: 4];
      else      io_in = {3'b000, pat[15-i]};
      sclk = 1'b0;
      tick(2);
      sclk = 1'b1;
      tick(2);
    end
    sclk = 1'b0;
  endtask

  task automatic frame(input logic [7:0] op, input logic quad);
    sel();
    shift({op, op}, quad ? 2 : 8, quad);
    desel();
  endtask

  task automatic go_deep(input logic quad);
    frame(8'hB9, quad);
    tick(TDP + 4);
  endtask

  task automatic t_reset();
    chk("R1 mode", pwr_mode, 1);
    chk("R1 block", cmd_block, 0);
    chk("R1 id_start", id_start, 0);
    sel();
    chk("R1 active code while selected", pwr_mode, 0);
    desel();
  endtask

  task automatic t_single_sleep();
    int ids;
    frame(8'hB9, 1'b0);
    chk("R2 block after single-line sleep", cmd_block, 1);
    chk("R5 standby during delay", pwr_mode, 1);
    tick(TDP - 8);
    chk("R5 still standby before delay end", pwr_mode, 1);
    tick(12);
    chk("R5 deep after delay", pwr_mode, 2);
    ids = id_cnt;
    sel();
    shift({8'hAB, 8'h00}, 8, 1'b0);
    tick(2);
    chk("R7 block cleared by wake", cmd_block, 0);
    chk("R7 active while selected", pwr_mode, 0);
    chk("R8 one id pulse", id_cnt - ids, 1);
    desel();
    chk("R7 standby after deselect", pwr_mode, 1);
  endtask

  task automatic t_quad_sleep();
    frame(8'hB9, 1'b1);
    chk("R3 block after quad sleep", cmd_block, 1);
    tick(TDP + 4);
    chk("R3 deep after quad sleep", pwr_mode, 2);
    frame(8'hAB, 1'b1);
    chk("R3 quad wake", cmd_block, 0);
    // nibble order: 0x9B must not be taken as sleep
    frame(8'h9B, 1'b1);
    tick(TDP + 4);
    chk("R3 swapped nibbles ignored", cmd_block, 0);
  endtask

  task automatic t_bad_len();
    int lens[3] = '{7, 9, 16};
    foreach (lens[k]) begin
      sel();
      shift(16'hB9B9, lens[k], 1'b0);
      desel();
      tick(TDP + 4);
      chk($sformatf("R4 %0d-bit sleep dropped block", lens[k]), cmd_block, 0);
      chk($sformatf("R4 %0d-bit sleep dropped mode", lens[k]), pwr_mode, 1);
    end
    for (int n = 1; n <= 3; n += 2) begin
      sel();
      shift(16'hB9B9, n, 1'b1);
      desel();
      tick(TDP + 4);
      chk($sformatf("R4 %0d-nibble sleep dropped", n), cmd_block, 0);
    end
  endtask

  task automatic t_ignore_deep();
    logic [7:0] ops[5] = '{8'h06, 8'h02, 8'h20, 8'hC7, 8'hB9};
    int ids;
    go_deep(1'b0);
    ids = id_cnt;
    foreach (ops[k]) begin
      frame(ops[k], 1'b0);
      chk($sformatf("R6 opcode %02h ignored mode", ops[k]), pwr_mode, 2);
      chk($sformatf("R6 opcode %02h ignored block", ops[k]), cmd_block, 1);
    end
    chk("R6 no id pulse while ignored", id_cnt - ids, 0);
    frame(8'hAB, 1'b0);
  endtask

  task automatic t_reset_pair();
    go_deep(1'b0);
    frame(8'h66, 1'b0);
    chk("R9 enable alone keeps deep", pwr_mode, 2);
    frame(8'h99, 1'b0);
    chk("R9 pair exits deep block", cmd_block, 0);
    chk("R9 pair exits deep mode", pwr_mode, 1);
    go_deep(1'b1);
    frame(8'h66, 1'b1);
    frame(8'h05, 1'b1);
    frame(8'h99, 1'b1);
    chk("R9 interposed frame disarms", pwr_mode, 2);
    frame(8'h66, 1'b0);
    frame(8'h99, 1'b0);
    chk("R9 pair works again", cmd_block, 0);
  endtask

  task automatic t_busy();
    busy = 1'b1;
    tick(1);
    chk("R10 active while busy", pwr_mode, 0);
    frame(8'hB9, 1'b0);
    chk("R10 sleep rejected while busy", cmd_block, 0);
    busy = 1'b0;
    tick(1);
    chk("R10 standby after busy", pwr_mode, 1);
    tick(TDP + 4);
    chk("R10 rejected sleep never lands", pwr_mode, 1);
    // busy rises on the same edge that ends a valid sleep frame
    sel();
    shift({8'hB9, 8'h00}, 8, 1'b0);
    busy = 1'b1;
    cs_n = 1'b1;
    tick(3);
    chk("R10 collision rejected", cmd_block, 0);
    busy = 1'b0;
    tick(TDP + 4);
    chk("R10 collision no deep", pwr_mode, 1);
  endtask

  task automatic t_wake_race();
    int ids;
    for (int d = 0; d <= 12; d++) begin
      ids = id_cnt;
      frame(8'hB9, 1'b1);
      tick(d);
      frame(8'hAB, 1'b1);
      tick(TDP + 4);
      chk($sformatf("R7 wake race gap %0d", d), {pwr_mode, cmd_block}, {2'd1, 1'b0});
      chk($sformatf("R8 wake race id gap %0d", d), id_cnt - ids, 1);
    end
    ids = id_cnt;
    frame(8'hAB, 1'b0);
    chk("R8 id pulse while awake", id_cnt - ids, 1);
    chk("R8 pulse width one", id_wide, 0);
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_single_sleep();
    t_quad_sleep();
    t_bad_len();
    t_ignore_deep();
    t_reset_pair();
    t_busy();
    t_wake_race();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule